// File: doc/BRIEF.md
# PWM Time-Base Counter with Phase Sync

This block is the time base of a pulse-width modulation generator. A prescaler divides the system clock into count enables. A 16-bit counter steps on each enable. It counts upward, downward, or up and then down in a triangle. The period that bounds the count can be written directly, or held in a shadow copy that is only applied when the counter returns to zero. That lets software retime a running waveform without a shortened or stretched cycle.

Several of these time bases can be kept in lock-step. An external sync pulse loads the counter with a programmable phase value and restarts the prescaler. The block's own sync output pulses each time its counter reaches zero, so it can drive the sync input of the next module in a chain. The block also drives one-cycle zero-match and period-match strobes for the compare logic downstream, and a sticky interrupt request.

Top module: `pwm_timebase`

## Requirements
- R1: The prescaler register (address 1, bits 7:0) holds a value N; with N from 1 to 255 the counter steps once every N clocks while running, and N = 0 behaves exactly like N = 1.
- R2: Mode field value 0 (control register address 0, bits 1:0) counts up from 0 to the active period P and then wraps to 0; mode value 3 behaves like mode 0.
- R3: Mode value 1 counts down to 0 and then reloads P; starting from the reset value 0, the first step loads P.
- R4: Mode value 2 counts up to P, then down to 0, then up again, turning at both ends (0,1,..,P,P-1,..,0,1,..).
- R5: With the shadow bit (control bit 2) set, a write to the period register (address 2) leaves the active period unchanged until a count step lands the counter on 0, and the new value is used from then on.
- R6: With the shadow bit clear, a period write becomes the active period on the clock edge that stores it.
- R7: A high sync input loads the counter with the phase register (address 3) on the next clock edge, takes priority over a count step, and restarts the prescaler so that the next step comes a full prescaler interval later.
- R8: The zero strobe is high for exactly the cycle in which a count step has just put 0 on the counter output; the period strobe likewise marks a step that has just put P on it. A sync load raises neither strobe.
- R9: The sync output pulses high for one cycle in every cycle in which the zero strobe is high, and is low otherwise.
- R10: The interrupt request is set by a zero strobe and stays set until a write of 1 in bit 0 to address 4; a write with bit 0 clear has no effect, and a zero event in the same cycle as a clearing write leaves it set.
- R11: While the run input is low, the counter value and the prescaler hold their state.
- R12: After reset the counter output, both strobes, the sync output and the interrupt request are 0; the mode is up, shadowing is off, the prescaler is 0 and the active period is 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Time-base enable; low freezes counting |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address (0 control, 1 prescaler, 2 period, 3 phase, 4 interrupt clear) |
| wr_data_i | input | 16 | Register write data |
| sync_i | input | 1 | Phase-load request from an upstream module |
| sync_o | output | 1 | One-cycle pulse when the counter reaches zero, for chaining |
| cnt_o | output | 16 | Present counter value |
| zero_o | output | 1 | Zero-match event strobe |
| prd_o | output | 1 | Period-match event strobe |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The bench targets the turning points of each mode. A design that turned one step late in up-down mode would show P+1 or wrap below 0, and one whose down mode ignored the reload would stick at zero. It also checks that a divisor of 0 matches a divisor of 1; a design that divided by 256 there would crawl. A period write is placed mid-cycle with shadowing on and then with it off; a design that applied the shadow copy early would wrap short, and one that applied it late would overrun. The remaining checks cover sync timing, where a design that did not restart the prescaler would step too soon after the phase load, and the interrupt where set and clear collide; a design that let the clear win would drop a zero event.

// File: rtl/pwm_tbase_pkg.sv
package pwm_tbase_pkg;

    typedef enum logic [1:0] {
        CM_UP   = 2'd0,
        CM_DOWN = 2'd1,
        CM_UPDN = 2'd2,
        CM_RSVD = 2'd3
    } cnt_mode_e;

    localparam int unsigned REG_CTRL   = 0;
    localparam int unsigned REG_PSC    = 1;
    localparam int unsigned REG_PERIOD = 2;
    localparam int unsigned REG_PHASE  = 3;
    localparam int unsigned REG_IRQCLR = 4;

endpackage

// File: rtl/pt_prescaler.sv
module pt_prescaler #(
    parameter int unsigned PSC_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [PSC_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PSC_W-1:0] pre;
    } pre_state_t;

    pre_state_t s_d, s_q;
    logic [PSC_W-1:0] lim;
    logic at_lim;

    always_comb begin
        lim    = (div_i == '0) ? '0 : div_i - 1'b1;
        at_lim = (s_q.pre >= lim);
        s_d    = s_q;
        if (restart_i) begin
            s_d.pre = '0;
        end else if (run_i) begin
            s_d.pre = at_lim ? '0 : s_q.pre + 1'b1;
        end
        tick_o = run_i && !restart_i && at_lim;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R1: with a divisor above one, two enables never come back to back
    a_r1_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && lim != '0) |=> (!tick_o || div_i != $past(div_i)));

    // R11: a stopped prescaler keeps its position
    a_r11_pre_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !restart_i) |=> $stable(s_q.pre));

endmodule

// File: rtl/pt_counter.sv
module pt_counter
    import pwm_tbase_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             sync_i,
    input  logic [CNT_W-1:0] phase_i,
    input  logic [CNT_W-1:0] period_i,
    input  cnt_mode_e        mode_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o,
    output logic             pmatch_o,
    output logic             zero_step_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic             zero;
        logic             pm;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic [CNT_W-1:0] nxt;
    logic nxt_down;

    always_comb begin
        nxt      = s_q.cnt;
        nxt_down = 1'b0;
        unique case (mode_i)
            CM_DOWN: begin
                nxt = (s_q.cnt == '0) ? period_i : s_q.cnt - 1'b1;
            end
            CM_UPDN: begin
                if (!s_q.down) begin
                    if (s_q.cnt >= period_i) begin
                        nxt_down = 1'b1;
                        nxt      = (s_q.cnt == '0) ? '0 : s_q.cnt - 1'b1;
                    end else begin
                        nxt = s_q.cnt + 1'b1;
                    end
                end else begin
                    if (s_q.cnt == '0) begin
                        nxt_down = 1'b0;
                        nxt      = (period_i == '0) ? '0 : CNT_W'(1);
                    end else begin
                        nxt_down = 1'b1;
                        nxt      = s_q.cnt - 1'b1;
                    end
                end
            end
            default: begin
                nxt = (s_q.cnt >= period_i) ? '0 : s_q.cnt + 1'b1;
            end
        endcase

        s_d      = s_q;
        s_d.zero = 1'b0;
        s_d.pm   = 1'b0;
        if (sync_i) begin
            s_d.cnt = phase_i;
        end else if (tick_i) begin
            s_d.cnt  = nxt;
            s_d.down = nxt_down;
            s_d.zero = (nxt == '0);
            s_d.pm   = (nxt == period_i);
        end
        zero_step_o = tick_i && !sync_i && (nxt == '0);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o    = s_q.cnt;
    assign zero_o   = s_q.zero;
    assign pmatch_o = s_q.pm;

    // R8: a zero strobe only accompanies a zero count
    a_r8_zero_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zero_o |-> (cnt_o == '0));

    // R8: a period strobe shows the period that was active at the step
    a_r8_pm_on_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pmatch_o |-> (cnt_o == $past(period_i)));

    // R7: sync loads the phase value on the next edge
    a_r7_sync_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_i |=> (cnt_o == $past(phase_i)));

    // R11: no enable and no sync keeps the counter still
    a_r11_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !sync_i) |=> $stable(cnt_o));

    // R2: below the period, up mode advances by one
    a_r2_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == CM_UP && tick_i && !sync_i && cnt_o < period_i)
            |=> (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tbase_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned PSC_W  = 8,
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic              sync_i,
    output logic              sync_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              zero_o,
    output logic              prd_o,
    output logic              irq_o
);

    localparam logic [CNT_W-1:0] PRD_RST = '1;

    typedef struct packed {
        cnt_mode_e        mode;
        logic             shadow;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] prd_sh;
        logic [CNT_W-1:0] prd_act;
        logic [CNT_W-1:0] phase;
        logic             irq;
    } reg_state_t;

    reg_state_t r_d, r_q;
    logic tick;
    logic zero_step;
    logic clr_req;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned reg_idx);
        return a == ADDR_W'(reg_idx);
    endfunction

    always_comb begin
        r_d     = r_q;
        clr_req = wr_en_i && hit(wr_addr_i, REG_IRQCLR) && wr_data_i[0];
        if (wr_en_i) begin
            if (hit(wr_addr_i, REG_CTRL)) begin
                r_d.mode   = cnt_mode_e'(wr_data_i[1:0]);
                r_d.shadow = wr_data_i[2];
            end
            if (hit(wr_addr_i, REG_PSC)) begin
                r_d.psc = wr_data_i[PSC_W-1:0];
            end
            if (hit(wr_addr_i, REG_PERIOD)) begin
                r_d.prd_sh = wr_data_i;
                if (!r_q.shadow) begin
                    r_d.prd_act = wr_data_i;
                end
            end
            if (hit(wr_addr_i, REG_PHASE)) begin
                r_d.phase = wr_data_i;
            end
        end
        if (r_q.shadow && zero_step) begin
            r_d.prd_act = r_q.prd_sh;
        end
        if (clr_req) begin
            r_d.irq = 1'b0;
        end
        if (zero_step) begin
            r_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q         <= '0;
            r_q.mode    <= CM_UP;
            r_q.prd_sh  <= PRD_RST;
            r_q.prd_act <= PRD_RST;
        end else begin
            r_q <= r_d;
        end
    end

    pt_prescaler #(
        .PSC_W (PSC_W)
    ) u_psc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run_i),
        .restart_i (sync_i),
        .div_i     (r_q.psc),
        .tick_o    (tick)
    );

    pt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick),
        .sync_i      (sync_i),
        .phase_i     (r_q.phase),
        .period_i    (r_q.prd_act),
        .mode_i      (r_q.mode),
        .cnt_o       (cnt_o),
        .zero_o      (zero_o),
        .pmatch_o    (prd_o),
        .zero_step_o (zero_step)
    );

    assign sync_o = zero_o;
    assign irq_o  = r_q.irq;

    // R10: the request stays up unless a clearing write arrives
    a_r10_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !clr_req) |=> irq_o);

    // R10: every zero strobe finds the request raised
    a_r10_irq_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zero_o |-> irq_o);

    // R5: with shadowing on, the active period moves only at a zero step
    a_r5_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.shadow && !zero_step) |=> $stable(r_q.prd_act));

endmodule

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb_top;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        run_i = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        sync_i = 1'b0;
    logic        sync_o;
    logic [15:0] cnt_o;
    logic        zero_o;
    logic        prd_o;
    logic        irq_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    pwm_timebase dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_ni),
        .run_i     (run_i),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .sync_i    (sync_i),
        .sync_o    (sync_o),
        .cnt_o     (cnt_o),
        .zero_o    (zero_o),
        .prd_o     (prd_o),
        .irq_o     (irq_o)
    );

    // vector: {mode[1:0], prescale[7:0], period[15:0]}
    localparam int NV = 7;
    localparam logic [25:0] VECS [NV] = '{
        {2'd0, 8'd0, 16'd4},
        {2'd0, 8'd3, 16'd5},
        {2'd1, 8'd1, 16'd3},
        {2'd1, 8'd2, 16'd6},
        {2'd2, 8'd0, 16'd3},
        {2'd2, 8'd4, 16'd2},
        {2'd3, 8'd0, 16'd2}
    };

    // reference model of the requirements, used by the vector walk
    logic        m_on = 1'b0;
    logic [1:0]  m_mode;
    logic [7:0]  m_lim;
    logic [7:0]  m_pre;
    logic [15:0] m_prd;
    logic [15:0] m_cnt;
    logic        m_dn;
    logic        m_zero;
    logic        m_pm;
    logic        m_tick;

    always @(posedge clk) begin
        if (m_on) begin
            m_zero = 1'b0;
            m_pm   = 1'b0;
            if (run_i) begin
                m_tick = (m_pre >= m_lim);
                m_pre  = m_tick ? 8'd0 : m_pre + 8'd1;
                if (m_tick) begin
                    if (m_mode == 2'd1) begin
                        m_cnt = (m_cnt == 0) ? m_prd : m_cnt - 16'd1;
                    end else if (m_mode == 2'd2) begin
                        if (!m_dn) begin
                            if (m_cnt >= m_prd) begin
                                m_dn  = 1'b1;
                                m_cnt = (m_cnt == 0) ? 16'd0 : m_cnt - 16'd1;
                            end else begin
                                m_cnt = m_cnt + 16'd1;
                            end
                        end else if (m_cnt == 0) begin
                            m_dn  = 1'b0;
                            m_cnt = (m_prd == 0) ? 16'd0 : 16'd1;
                        end else begin
                            m_cnt = m_cnt - 16'd1;
                        end
                    end else begin
                        m_cnt = (m_cnt >= m_prd) ? 16'd0 : m_cnt + 16'd1;
                    end
                    m_zero = (m_cnt == 0);
                    m_pm   = (m_cnt == m_prd);
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_ni = 1'b0;
        run_i  = 1'b0;
        sync_i = 1'b0;
        wr_en  = 1'b0;
        wait_cyc(2);
        rst_ni = 1'b1;
        wait_cyc(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R12: reset state
        do_reset();
        check("R12 cnt", cnt_o, 0);
        check("R12 zero", zero_o, 0);
        check("R12 prd", prd_o, 0);
        check("R12 sync_o", sync_o, 0);
        check("R12 irq", irq_o, 0);

        // R1 R2 R3 R4 R8: vector walk against the reference model
        for (int v = 0; v < NV; v++) begin
            int errs;
            string tag;
            errs = 0;
            do_reset();
            wr(3'd0, {14'd0, VECS[v][25:24]});
            wr(3'd1, {8'd0, VECS[v][23:16]});
            wr(3'd2, VECS[v][15:0]);
            m_mode = VECS[v][25:24];
            m_lim  = (VECS[v][23:16] == 0) ? 8'd0 : VECS[v][23:16] - 8'd1;
            m_prd  = VECS[v][15:0];
            m_pre  = 8'd0;
            m_cnt  = 16'd0;
            m_dn   = 1'b0;
            m_zero = 1'b0;
            m_pm   = 1'b0;
            m_on   = 1'b1;
            run_i  = 1'b1;
            tag = (m_mode == 2'd1) ? "R3 R1 R8" : (m_mode == 2'd2) ? "R4 R1 R8" : "R2 R1 R8";
            for (int c = 0; c < 60; c++) begin
                @(negedge clk);
                if (cnt_o !== m_cnt || zero_o !== m_zero || prd_o !== m_pm) begin
                    if (errs == 0) begin
                        $display("FAIL %s vec%0d cyc%0d actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                                 tag, v, c, cnt_o, zero_o, prd_o, m_cnt, m_zero, m_pm);
                    end
                    errs++;
                end
            end
            m_on  = 1'b0;
            run_i = 1'b0;
            total++;
            if (errs != 0) bad++;
        end

        // R11: run low freezes the counter
        do_reset();
        wr(3'd2, 16'd100);
        run_i = 1'b1;
        wait_cyc(5);
        check("R11 running", cnt_o, 5);
        run_i = 1'b0;
        wait_cyc(4);
        check("R11 held", cnt_o, 5);

        // R7 R1: sync loads phase and restarts the prescaler
        do_reset();
        wr(3'd2, 16'd1000);
        wr(3'd3, 16'd300);
        wr(3'd1, 16'd4);
        run_i = 1'b1;
        wait_cyc(6);
        sync_i = 1'b1;
        @(negedge clk);
        sync_i = 1'b0;
        check("R7 phase load", cnt_o, 300);
        wait_cyc(3);
        check("R7 prescaler restart", cnt_o, 300);
        wait_cyc(1);
        check("R7 R1 first step", cnt_o, 301);

        // R9: sync output follows zero strobes
        do_reset();
        wr(3'd2, 16'd3);
        run_i = 1'b1;
        begin
            int pulses;
            int mism;
            pulses = 0;
            mism = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                if (sync_o) pulses++;
                if (sync_o !== zero_o || (sync_o && cnt_o != 0)) mism++;
            end
            check("R9 pulse count", pulses, 5);
            check("R9 matches zero", mism, 0);
        end
        run_i = 1'b0;

        // R5: shadowed period waits for zero
        do_reset();
        wr(3'd2, 16'd6);
        wr(3'd0, 16'd4);
        run_i = 1'b1;
        wait_cyc(3);
        wr(3'd2, 16'd2);
        wait_cyc(2);
        check("R5 old period kept", cnt_o, 6);
        wait_cyc(3);
        check("R5 new period used", cnt_o, 2);
        wait_cyc(1);
        check("R5 wrap at new period", cnt_o, 0);
        run_i = 1'b0;

        // R6: unshadowed period applies at once
        do_reset();
        wr(3'd2, 16'd9);
        run_i = 1'b1;
        wait_cyc(3);
        wr(3'd2, 16'd4);
        wait_cyc(1);
        check("R6 immediate period", cnt_o, 0);
        run_i = 1'b0;

        // R10: sticky interrupt, write-1 clear, set wins
        do_reset();
        wr(3'd2, 16'd2);
        run_i = 1'b1;
        wait_cyc(3);
        check("R10 set on zero", irq_o, 1);
        run_i = 1'b0;
        wait_cyc(2);
        wr(3'd4, 16'd0);
        check("R10 zero write ignored", irq_o, 1);
        wr(3'd4, 16'd1);
        check("R10 cleared", irq_o, 0);
        run_i = 1'b1;
        wait_cyc(2);
        wr(3'd4, 16'd1);
        check("R10 set wins over clear", irq_o, 1);
        run_i = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule